// File: doc/BRIEF.md
# Lockable Host Configuration Base Address

This block sits on the core side of a host bus bridge and decides where, in host I/O space, a pair of configuration ports (an index port and a data port) answers. Firmware programs a 16-bit base address through two byte registers, then seals it with a lock bit. A valid flag records whether a usable address is held. The block compares each decoded LPC I/O address from the host side against that base and raises a hit for the index port (base) or the data port (base+1), but only while the address is valid.

An update always runs as one sequence. First, firmware clears the valid flag by writing 1 to it, which also forgets any earlier byte writes. Next it writes the low byte, whose bit 0 is always stored as 0. Then it writes the high byte. Finally it writes 1 to the lock bit, which makes the address valid. Once locked, the byte registers ignore writes, and only the main power-up reset unlocks them. If programmable mode is off, a strap input picks one of two fixed even base addresses. Such an address is always treated as valid.

Top module: `hostCfgBase`

## Requirements
- R1: After power-up reset the low byte, high byte, lock and valid read as 0, cfgValid is 0 in programmable mode, and no hit is raised.
- R2: A write to the low byte register stores bit 0 as 0, whatever value was written to that bit.
- R3: The core register offsets are fixed. Offset 0 is the low byte and offset 1 is the high byte. Offset 2 is control, with bit 0 holding valid and bit 1 holding lock. Offset 3 reads as 0. Reads are combinational on coreAddr.
- R4: Writing 1 to control bit 1 sets lock. The same write sets valid only if both byte registers have been written since the last valid clear or reset. Byte writes alone never set valid.
- R5: Writing 1 to control bit 0 clears valid and forgets earlier byte writes. Writing 0 to that bit has no effect. If a single write sets both bits, the clear wins: valid ends at 0 and lock ends at 1.
- R6: While lock is 1, writes to offsets 0 and 1 leave the stored bytes unchanged.
- R7: Lock stays 1 until power-up reset, including when 0 is written to control bit 1.
- R8: While the effective address is not valid, idxHit and dataHit stay 0 for any host address and strobe.
- R9: While valid, idxHit is 1 when hostRd or hostWr is 1 and hostAddr equals the base, and dataHit is 1 under the same strobes when hostAddr equals base+1. Both are 0 without a strobe or at any other address.
- R10: With progMode at 0, the base is FIXED_BASE_A when strapSel is 0 and FIXED_BASE_B when strapSel is 1. cfgValid is 1, and hits follow R9 whatever the registers hold.
- R11: If valid is cleared after lock has been set, writing the lock bit again does not set valid, so the ports stay silent until power-up reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| pwrUpRstN | input | 1 | Main power-up reset, active low, asynchronous |
| progMode | input | 1 | 1 selects the programmable base, 0 selects the strap-chosen fixed base |
| strapSel | input | 1 | Chooses between the two fixed base addresses |
| coreWr | input | 1 | Core register write strobe |
| coreAddr | input | 2 | Core register offset |
| coreWrData | input | 8 | Core write data |
| coreRdData | output | 8 | Core read data for coreAddr |
| hostAddr | input | 16 | Decoded LPC I/O address |
| hostRd | input | 1 | Host I/O read strobe |
| hostWr | input | 1 | Host I/O write strobe |
| cfgValid | output | 1 | Effective base address is valid |
| idxHit | output | 1 | Host cycle targets the index port |
| dataHit | output | 1 | Host cycle targets the data port |

## Verification
A wrong lock or valid state inside the block shows at the ports in the cycle right after the write that caused it. The control readback changes, and a byte write that should have been ignored reads back changed, or one that should have landed does not. The errors that matter most are a stale record of earlier byte writes and the wrong priority inside a combined control write. Both show only as a wrong cfgValid, and as hits that appear or vanish, one cycle after the lock write, so the bench probes the host ports right after every control write.

// File: rtl/hostCfgBasePkg.sv
package hostCfgBasePkg;
  localparam int REG_AW = 2;
  localparam logic [REG_AW-1:0] REG_LO  = 2'd0;
  localparam logic [REG_AW-1:0] REG_HI  = 2'd1;
  localparam logic [REG_AW-1:0] REG_CTL = 2'd2;
  localparam int CTL_VALID_BIT = 0;
  localparam int CTL_LOCK_BIT  = 1;

  // strobes and state handed from control to datapath
  typedef struct packed {
    logic loWe;
    logic hiWe;
    logic locked;
    logic validReg;
  } cfgStrobe_t;
endpackage

// File: rtl/hostCfgBaseCtrl.sv
module hostCfgBaseCtrl
  import hostCfgBasePkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              coreWr,
  input  logic [REG_AW-1:0] coreAddr,
  input  logic [1:0]        ctlBits,
  output cfgStrobe_t        stb
);
  logic lockQ, validQ, loSeenQ, hiSeenQ;
  logic wrLo, wrHi, wrCtl, clrValid, setLock;

  always_comb begin
    wrLo     = coreWr && (coreAddr == REG_LO);
    wrHi     = coreWr && (coreAddr == REG_HI);
    wrCtl    = coreWr && (coreAddr == REG_CTL);
    clrValid = wrCtl && ctlBits[CTL_VALID_BIT];
    setLock  = wrCtl && ctlBits[CTL_LOCK_BIT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockQ   <= 1'b0;
      validQ  <= 1'b0;
      loSeenQ <= 1'b0;
      hiSeenQ <= 1'b0;
    end else begin
      if (setLock) lockQ <= 1'b1;
      if (clrValid) begin
        validQ  <= 1'b0;
        loSeenQ <= 1'b0;
        hiSeenQ <= 1'b0;
      end else begin
        if (wrLo && !lockQ) loSeenQ <= 1'b1;
        if (wrHi && !lockQ) hiSeenQ <= 1'b1;
        if (setLock && loSeenQ && hiSeenQ) validQ <= 1'b1;
      end
    end
  end

  always_comb begin
    stb.loWe     = wrLo && !lockQ;
    stb.hiWe     = wrHi && !lockQ;
    stb.locked   = lockQ;
    stb.validReg = validQ;
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> lockQ); // R7
  AST_VALID_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(validQ) |-> lockQ); // R4
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (clrValid && setLock) |=> (!validQ && lockQ)); // R5
endmodule

// File: rtl/hostCfgBaseDp.sv
module hostCfgBaseDp
  import hostCfgBasePkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 2 * BYTE_W,
  parameter logic [ADDR_W-1:0] FIXED_BASE_A = 16'h002E,
  parameter logic [ADDR_W-1:0] FIXED_BASE_B = 16'h004E
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        stb,
  input  logic [BYTE_W-1:0] coreWrData,
  input  logic [REG_AW-1:0] coreAddr,
  output logic [BYTE_W-1:0] coreRdData,
  input  logic              progMode,
  input  logic              strapSel,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostRd,
  input  logic              hostWr,
  output logic              cfgValid,
  output logic              idxHit,
  output logic              dataHit
);
  logic [BYTE_W-1:0] addrLoQ, addrHiQ;
  logic [ADDR_W-1:0] effBase, idxAddr, dataAddr;
  logic              effValid, hostCyc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrLoQ <= '0;
      addrHiQ <= '0;
    end else begin
      if (stb.loWe) addrLoQ <= {coreWrData[BYTE_W-1:1], 1'b0};
      if (stb.hiWe) addrHiQ <= coreWrData;
    end
  end

  always_comb begin
    coreRdData = '0;
    case (coreAddr)
      REG_LO:  coreRdData = addrLoQ;
      REG_HI:  coreRdData = addrHiQ;
      REG_CTL: begin
        coreRdData[CTL_VALID_BIT] = stb.validReg;
        coreRdData[CTL_LOCK_BIT]  = stb.locked;
      end
      default: coreRdData = '0;
    endcase
  end

  always_comb begin
    if (progMode) begin
      effBase  = {addrHiQ, addrLoQ};
      effValid = stb.validReg;
    end else begin
      effBase  = strapSel ? FIXED_BASE_B : FIXED_BASE_A;
      effValid = 1'b1;
    end
    idxAddr  = {effBase[ADDR_W-1:1], 1'b0};
    dataAddr = {effBase[ADDR_W-1:1], 1'b1};
    hostCyc  = hostRd || hostWr;
    cfgValid = effValid;
    idxHit   = effValid && hostCyc && (hostAddr == idxAddr);
    dataHit  = effValid && hostCyc && (hostAddr == dataAddr);
  end

  AST_LOCKED_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    stb.locked |=> $stable({addrHiQ, addrLoQ})); // R6
  AST_LO_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    addrLoQ[0] == 1'b0); // R2
  AST_SILENT_INVALID: assert property (@(posedge clk) disable iff (!rstN)
    !cfgValid |-> (!idxHit && !dataHit)); // R8
  AST_HIT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (!hostRd && !hostWr) |-> (!idxHit && !dataHit)); // R9
endmodule

// File: rtl/hostCfgBase.sv
module hostCfgBase
  import hostCfgBasePkg::*;
#(
  parameter logic [15:0] FIXED_BASE_A = 16'h002E,
  parameter logic [15:0] FIXED_BASE_B = 16'h004E
) (
  input  logic        clk,
  input  logic        pwrUpRstN,
  input  logic        progMode,
  input  logic        strapSel,
  input  logic        coreWr,
  input  logic [1:0]  coreAddr,
  input  logic [7:0]  coreWrData,
  output logic [7:0]  coreRdData,
  input  logic [15:0] hostAddr,
  input  logic        hostRd,
  input  logic        hostWr,
  output logic        cfgValid,
  output logic        idxHit,
  output logic        dataHit
);
  cfgStrobe_t stb;

  hostCfgBaseCtrl uCtrl (
    .clk      (clk),
    .rstN     (pwrUpRstN),
    .coreWr   (coreWr),
    .coreAddr (coreAddr),
    .ctlBits  (coreWrData[1:0]),
    .stb      (stb)
  );

  hostCfgBaseDp #(
    .BYTE_W       (8),
    .ADDR_W       (16),
    .FIXED_BASE_A (FIXED_BASE_A),
    .FIXED_BASE_B (FIXED_BASE_B)
  ) uDp (
    .clk        (clk),
    .rstN       (pwrUpRstN),
    .stb        (stb),
    .coreWrData (coreWrData),
    .coreAddr   (coreAddr),
    .coreRdData (coreRdData),
    .progMode   (progMode),
    .strapSel   (strapSel),
    .hostAddr   (hostAddr),
    .hostRd     (hostRd),
    .hostWr     (hostWr),
    .cfgValid   (cfgValid),
    .idxHit     (idxHit),
    .dataHit    (dataHit)
  );
endmodule

// File: tb/tb_hostCfgBase.sv
`timescale 1ns/1ps
module tb_hostCfgBase;
  logic clk = 0;
  logic pwrUpRstN = 0;
  logic progMode = 1, strapSel = 0, coreWr = 0, hostRd = 0, hostWr = 0;
  logic [1:0] coreAddr = 0;
  logic [7:0] coreWrData = 0;
  logic [15:0] hostAddr = 0;
  logic [7:0] coreRdData;
  logic cfgValid, idxHit, dataHit;

  int compared = 0, mismatched = 0;
  logic [7:0] mLo, mHi;
  logic mLock, mValid, mLoSeen, mHiSeen;

  always #2 clk = ~clk;

  hostCfgBase dut (.*);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mBase();
    if (progMode) return {mHi, mLo};
    return strapSel ? 16'h004E : 16'h002E;
  endfunction

  function automatic logic mEffValid();
    return progMode ? mValid : 1'b1;
  endfunction

  task automatic modelReset();
    mLo = 0; mHi = 0; mLock = 0; mValid = 0; mLoSeen = 0; mHiSeen = 0;
  endtask

  task automatic doReset();
    @(negedge clk); pwrUpRstN = 0; modelReset();
    @(negedge clk); @(negedge clk); pwrUpRstN = 1;
  endtask

  task automatic coreWrite(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    coreAddr = a; coreWrData = d; coreWr = 1;
    @(negedge clk);
    coreWr = 0;
    case (a)
      2'd0: if (!mLock) begin mLo = {d[7:1], 1'b0}; mLoSeen = 1; end
      2'd1: if (!mLock) begin mHi = d; mHiSeen = 1; end
      2'd2: begin
        if (d[1]) begin
          if (!d[0] && mLoSeen && mHiSeen) mValid = 1;
          mLock = 1;
        end
        if (d[0]) begin mValid = 0; mLoSeen = 0; mHiSeen = 0; end
      end
      default: ;
    endcase
  endtask

  task automatic checkRegs(string req);
    coreAddr = 2'd0; #1 chk({req, " lo"}, {8'h0, coreRdData}, {8'h0, mLo});
    coreAddr = 2'd1; #1 chk({req, " hi"}, {8'h0, coreRdData}, {8'h0, mHi});
    coreAddr = 2'd2; #1 chk({req, " ctl"}, {8'h0, coreRdData}, {14'h0, mLock, mValid});
    coreAddr = 2'd3; #1 chk({req, " off3"}, {8'h0, coreRdData}, 16'h0);
    chk({req, " cfgValid"}, {15'h0, cfgValid}, {15'h0, mEffValid()});
  endtask

  task automatic probe(string req, logic [15:0] a, logic rd, logic wr);
    logic eI, eD;
    hostAddr = a; hostRd = rd; hostWr = wr;
    #1;
    eI = mEffValid() && (rd || wr) && (a == {mBase()[15:1], 1'b0});
    eD = mEffValid() && (rd || wr) && (a == {mBase()[15:1], 1'b1});
    chk({req, " hits"}, {14'h0, idxHit, dataHit}, {14'h0, eI, eD});
    hostRd = 0; hostWr = 0;
  endtask

  initial begin
    #(4 * 200000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    doReset();
    @(negedge clk);
    checkRegs("R1");
    probe("R1 R8", 16'h0000, 1, 0);
    probe("R1", 16'h0001, 0, 1);

    // program sequence
    coreWrite(2'd2, 8'h01);
    coreWrite(2'd0, 8'h5F);
    checkRegs("R2");
    chk("R2 lo even", {8'h0, mLo}, 16'h005E);
    coreWrite(2'd1, 8'h12);
    checkRegs("R4 before lock");
    probe("R8 unlocked", 16'h125E, 1, 0);
    coreWrite(2'd2, 8'h02);
    checkRegs("R4 after lock");
    chk("R4 cfgValid", {15'h0, cfgValid}, 16'h1);
    probe("R9 idx", 16'h125E, 1, 0);
    probe("R9 data", 16'h125F, 0, 1);
    probe("R9 other", 16'h125D, 1, 0);
    probe("R9 nostrobe", 16'h125E, 0, 0);
    coreWrite(2'd0, 8'h00);
    coreWrite(2'd1, 8'hFF);
    checkRegs("R6");
    coreWrite(2'd2, 8'h00);
    checkRegs("R7 R5 zero");
    coreWrite(2'd3, 8'hFF);
    checkRegs("R3");

    // fixed mode
    progMode = 0; strapSel = 0;
    #1 chk("R10 valid", {15'h0, cfgValid}, 16'h1);
    probe("R10 A idx", 16'h002E, 1, 0);
    probe("R10 A data", 16'h002F, 1, 0);
    strapSel = 1;
    probe("R10 B idx", 16'h004E, 0, 1);
    probe("R10 B data", 16'h004F, 1, 0);
    probe("R10 B notA", 16'h002E, 1, 0);
    progMode = 1; strapSel = 0;

    // clear after lock
    coreWrite(2'd2, 8'h01);
    checkRegs("R5 clear");
    probe("R8 cleared", 16'h125E, 1, 0);
    coreWrite(2'd2, 8'h02);
    checkRegs("R11 relock");
    probe("R11 silent", 16'h125E, 1, 1);

    // combined control write
    doReset();
    coreWrite(2'd0, 8'h40);
    coreWrite(2'd1, 8'h03);
    coreWrite(2'd2, 8'h03);
    checkRegs("R5 combined");
    chk("R5 combined lock", {15'h0, mLock}, 16'h1);
    doReset();
    checkRegs("R1 second reset");

    // random phase
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom % 8;
      if (op < 3) coreWrite(2'($urandom % 4), 8'($urandom));
      else if (op == 3) coreWrite(2'd2, 8'($urandom % 4));
      else if (op == 4) begin progMode = 1'($urandom); strapSel = 1'($urandom); end
      else if (op == 5 && ($urandom % 16) == 0) doReset();
      @(negedge clk);
      checkRegs("R3 random");
      probe("R9 random base", {mBase()[15:1], 1'($urandom)}, 1'($urandom), 1'($urandom));
      probe("R9 random any", 16'($urandom), 1, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule